// File: doc/BRIEF.md
# Split-Write Cycle Counter

This block keeps a 64-bit count that goes up by one on every clock while it runs. Software cannot load the full width in one access. It loads the value through two write ports that have already been decoded. The upper-half port takes data bits 63:32 into count bits 63:32. The control port takes data bits 31:0 into count bits 31:0, and data bit 32 of that same write sets the run state.

The full 64-bit count is always available on the read port. Count bits 3:0 cannot hold a loaded nonzero value. If a control write carries ones in those bits, the block clears them and raises an error pulse. A cycle that carries a write never increments. The half that is not written keeps its value, and no carry crosses between the halves.

Top module: `split_cycle_counter`

## Requirements
- R1: After reset, `count` is zero, `running` is 0 and `fmt_err` is 0.
- R2: While `running` is 1 and neither write strobe is high, `count` goes up by exactly one at each rising clock edge.
- R3: Incrementing from all ones gives zero, and the count keeps rising from there.
- R4: When `hi_we` is high and `ctl_we` is low, count bits 63:32 take `hi_data[63:32]`. Bits 31:0 keep their value, and there is no increment in that cycle.
- R5: When `ctl_we` is high and `hi_we` is low, count bits 31:4 take `ctl_data[31:4]`. Bits 63:32 keep their value, and there is no increment or carry in that cycle.
- R6: A control write sets `running` to the value of `ctl_data[32]`: 1 runs the counter and 0 stops it. `running` changes only on control writes.
- R7: Count bits 3:0 become 0 on every control write, whatever `ctl_data[3:0]` holds.
- R8: `fmt_err` is 1 for exactly the cycle after a control write whose `ctl_data[3:0]` is nonzero. Otherwise it is 0.
- R9: When both strobes are high in the same cycle, both halves load as in R4 and R5, and there is no increment.
- R10: While `running` is 0 and no write occurs, `count` holds its value.
- R11: `count` always shows the current full 64-bit register value, and the new value is visible after the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_we | input | 1 | Strobe that loads the upper half |
| hi_data | input | 64 | Upper-half write data; only bits 63:32 are used |
| ctl_we | input | 1 | Strobe that loads the lower half and the run state |
| ctl_data | input | 64 | Control write data: bits 31:0 are the count, bit 32 is the run state |
| count | output | 64 | Current count |
| running | output | 1 | Counter is enabled |
| fmt_err | output | 1 | One-cycle flag: nonzero low nibble on a control write |

## Verification
The hardest case to reach is the wrap, because the upper half must be all ones and the lower half close to all ones. A control write cannot leave the low nibble as ones. The stimulus therefore loads the upper half with all ones and the lower half with 0xFFFFFFF0 through two separate writes. It then lets the counter run across the boundary, so both the carry out of the lower half and the wrap to zero are seen. Collisions between writes and a running counter are reached by issuing writes while the counter is enabled.

// File: rtl/split_cycle_counter.sv
module split_cycle_counter #(
  parameter int HALF_W    = 32,
  parameter int ZERO_LSBS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_we,
  input  logic [2*HALF_W-1:0] hi_data,
  input  logic                ctl_we,
  input  logic [2*HALF_W-1:0] ctl_data,
  output logic [2*HALF_W-1:0] count,
  output logic                running,
  output logic                fmt_err
);
  localparam int W = 2 * HALF_W;

  logic [HALF_W-1:0] hi_q, lo_q;

  wire              bump    = running & ~hi_we & ~ctl_we;
  wire [HALF_W-1:0] lo_load = {ctl_data[HALF_W-1:ZERO_LSBS], {ZERO_LSBS{1'b0}}};
  wire [W-1:0]      bumped  = {hi_q, lo_q} + W'(1);
  wire              unused_bits = ^{hi_data[HALF_W-1:0], ctl_data[W-1:HALF_W+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      running <= 1'b0;
      fmt_err <= 1'b0;
    end else begin
      if (bump) begin
        {hi_q, lo_q} <= bumped;
      end else begin
        if (hi_we)  hi_q <= hi_data[W-1:HALF_W];
        if (ctl_we) lo_q <= lo_load;
      end
      if (ctl_we) running <= ctl_data[HALF_W];
      fmt_err <= ctl_we & (|ctl_data[ZERO_LSBS-1:0]);
    end
  end

  assign count = {hi_q, lo_q};
endmodule

// File: rtl/split_cycle_counter_chk.sv
module split_cycle_counter_chk #(
  parameter int HALF_W    = 32,
  parameter int ZERO_LSBS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hi_we,
  input logic [2*HALF_W-1:0] hi_data,
  input logic                ctl_we,
  input logic [2*HALF_W-1:0] ctl_data,
  input logic [2*HALF_W-1:0] count,
  input logic                running,
  input logic                fmt_err
);
  localparam int W = 2 * HALF_W;

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !hi_we && !ctl_we) |=> count == $past(count) + W'(1));

  assert_upper_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> count[W-1:HALF_W] == $past(hi_data[W-1:HALF_W]));

  assert_upper_keeps_lower_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !ctl_we) |=> count[HALF_W-1:0] == $past(count[HALF_W-1:0]));

  assert_lower_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> count[HALF_W-1:ZERO_LSBS] == $past(ctl_data[HALF_W-1:ZERO_LSBS]));

  assert_lower_keeps_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !hi_we) |=> count[W-1:HALF_W] == $past(count[W-1:HALF_W]));

  assert_run_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> running == $past(ctl_data[HALF_W]));

  assert_run_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(running));

  assert_low_nibble_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> count[ZERO_LSBS-1:0] == '0);

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we || ctl_data[ZERO_LSBS-1:0] == '0) |=> !fmt_err);

  assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !hi_we && !ctl_we) |=> $stable(count));
endmodule

bind split_cycle_counter split_cycle_counter_chk #(.HALF_W(HALF_W), .ZERO_LSBS(ZERO_LSBS)) u_chk (.*);

// File: tb/split_cycle_counter_test.sv
module split_cycle_counter_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_we = 1'b0, ctl_we = 1'b0;
  logic [63:0] hi_data = '0, ctl_data = '0;
  logic [63:0] count;
  logic        running, fmt_err;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [63:0] m_cnt = '0;
  bit          m_run = 1'b0;

  logic [63:0] q_cnt[$];
  bit          q_run[$];
  bit          q_err[$];
  string       q_tag[$];

  split_cycle_counter uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: drives one cycle at the falling edge and queues the expectation
  task automatic step(string tag, bit hw, logic [63:0] hd, bit cw, logic [63:0] cd);
    bit e_err;
    @(negedge clk);
    hi_we = hw; hi_data = hd; ctl_we = cw; ctl_data = cd;
    e_err = cw && (cd[3:0] != 4'h0);
    if (m_run && !hw && !cw) m_cnt = m_cnt + 64'd1;
    else begin
      if (hw) m_cnt[63:32] = hd[63:32];
      if (cw) m_cnt[31:0] = {cd[31:4], 4'h0};
    end
    if (cw) m_run = cd[32];
    q_cnt.push_back(m_cnt); q_run.push_back(m_run);
    q_err.push_back(e_err); q_tag.push_back(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, '0, 1'b0, '0);
  endtask

  // monitor: compares outputs a quarter period after the edge
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q_cnt.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check({t, " count"}, count, q_cnt.pop_front());
        check({t, " running"}, {63'd0, running}, {63'd0, q_run.pop_front()});
        check({t, " fmt_err"}, {63'd0, fmt_err}, {63'd0, q_err.pop_front()});
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*3 + 2);
    check("R1 count", count, '0);
    check("R1 running", {63'd0, running}, '0);
    check("R1 fmt_err", {63'd0, fmt_err}, '0);
    @(negedge clk); rst_n = 1'b1;
    idle("R10 stopped after reset", 3);
    step("R6 enable", 1'b0, '0, 1'b1, 64'h1_0000_0100);
    idle("R2 R11 running", 6);
    step("R4 upper write while running", 1'b1, 64'hABCD_1234_5555_5555, 1'b0, '0);
    idle("R2 after upper write", 3);
    step("R5 R7 R8 lower write dirty nibble", 1'b0, '0, 1'b1, 64'h1_1234_567F);
    idle("R8 flag drops R2", 2);
    step("R6 stop", 1'b0, '0, 1'b1, 64'h0_0000_0200);
    idle("R10 hold while stopped", 4);
    step("R9 both writes", 1'b1, 64'hFFFF_FFFF_0000_0000, 1'b1, 64'h0_FFFF_FFF3);
    idle("R10 hold after both", 2);
    step("R6 R3 enable near wrap", 1'b0, '0, 1'b1, 64'h1_FFFF_FFF0);
    idle("R3 wrap", 20);
    step("R9 both writes while running", 1'b1, 64'h0000_0001_0000_0000, 1'b1, 64'h1_0000_0010);
    idle("R2 after both writes", 3);
    step("R7 clean nibble no flag", 1'b0, '0, 1'b1, 64'h0_0000_0000);
    idle("R10 final hold", 2);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule